// File: doc/BRIEF.md
# Conversion Start and Busy Sequencer

This block paces the conversions of a sampling converter. After each conversion, and after reset, it counts out an acquisition window of fixed length. When that window closes it looks at the level of an asynchronous start request. If the request is low, it puts the sample-and-hold into hold and starts converting in the same step. If the request is high, it waits for the request's next falling edge and then starts, so the moment of sampling is set by that edge.

While a conversion runs, the block raises `busy_o` and `hold_o` for a fixed number of cycles. When `busy_o` drops, a one-cycle `latch_o` strobe tells the output shift register to capture the result. The falling edge of `busy_o` can therefore serve as data-ready. A high `rst` cancels any conversion at once and suppresses the strobe. A high `pwr_down` lets a running conversion finish but prevents new ones. When `pwr_down` is released, a fresh acquisition window begins.

The block has no data stream, so it has no valid/ready handshake. All of its pins are plain level controls and flags.

Top module: `conv_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `busy_o`, `hold_o` and `latch_o` are all low.
- R2: After `rst` is released with the start request held low, `busy_o` is first high after exactly `ACQ_CYC` rising clock edges.
- R3: If the start request is high when acquisition ends, no conversion starts while it stays high. After it falls, `busy_o` rises on the third clock edge: two synchronizer flops, then falling-edge detection.
- R4: Every conversion that is not cut short by reset keeps `busy_o` high for exactly `CONV_CYC` cycles.
- R5: `hold_o` is high exactly while `busy_o` is high.
- R6: `latch_o` is a single-cycle pulse. It is high in the first cycle in which `busy_o` is low after a completed conversion, and at no other time.
- R7: Acquisition restarts by itself after each conversion. With the request low, `busy_o` stays low for exactly `ACQ_CYC` cycles between conversions.
- R8: Raising `rst` during a conversion drives `busy_o` and `hold_o` low at the next clock edge and produces no `latch_o` pulse.
- R9: With `pwr_down` high, a conversion already in progress still runs its full `CONV_CYC` cycles, and no new conversion starts.
- R10: After `pwr_down` falls, with the request low, `busy_o` rises `ACQ_CYC + 1` clock edges later: one edge to leave power-down, then a full acquisition window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; aborts any conversion |
| start_req | input | 1 | Asynchronous conversion-start request |
| pwr_down | input | 1 | High blocks further conversions after the current one |
| hold_o | output | 1 | Sample-and-hold control, high while holding |
| busy_o | output | 1 | High while a conversion runs |
| latch_o | output | 1 | One-cycle strobe that loads the result register |

## Verification
The bench drives the start request in three ways. Holding it low from reset measures the immediate-start latency and the free-running gap between conversions. Holding it high across the end of acquisition and then dropping it shows that the block waits for the edge, and measures the synchronizer latency. The falling edge of `pwr_down` sets the restart latency. Each of these patterns produces a different, exactly known cycle count, so a wrong window length, a wrong synchronizer depth or a mode mix-up each shifts a measured number. A reset in the middle of a conversion and a long power-down interval show that abort and power-down suppress both the strobe and any further busy pulses.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_ACQ  = 2'd0,
    SEQ_ARM  = 2'd1,
    SEQ_CONV = 2'd2,
    SEQ_OFF  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/conv_seq_sync.sv
module conv_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign lvl  = chain_q[STAGES-1];
  assign fall = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/conv_seq_timer.sv
module conv_seq_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic clr,
  input  logic en,
  output logic last
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (clr)     cnt_q <= '0;
    else if (en) cnt_q <= cnt_q + 1'b1;
  end

  assign last = en && (cnt_q == W'(LIMIT - 1));
endmodule

// File: rtl/conv_seq_fsm.sv
module conv_seq_fsm
  import conv_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_down,
  input  logic       req_lvl,
  input  logic       req_fall,
  input  logic       acq_done,
  input  logic       conv_done,
  output seq_state_e state,
  output logic       latch_o
);
  seq_state_e state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      SEQ_ACQ: begin
        if (pwr_down)      state_d = SEQ_OFF;
        else if (acq_done) state_d = req_lvl ? SEQ_ARM : SEQ_CONV;
      end
      SEQ_ARM: begin
        if (pwr_down)      state_d = SEQ_OFF;
        else if (req_fall) state_d = SEQ_CONV;
      end
      SEQ_CONV: begin
        if (conv_done)     state_d = pwr_down ? SEQ_OFF : SEQ_ACQ;
      end
      SEQ_OFF: begin
        if (!pwr_down)     state_d = SEQ_ACQ;
      end
      default:             state_d = SEQ_ACQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SEQ_ACQ;
      latch_o <= 1'b0;
    end else begin
      state   <= state_d;
      latch_o <= (state == SEQ_CONV) && conv_done;
    end
  end
endmodule

// File: rtl/conv_seq.sv
module conv_seq
  import conv_seq_pkg::*;
#(
  parameter int ACQ_CYC     = 8,
  parameter int CONV_CYC    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start_req,
  input  logic pwr_down,
  output logic hold_o,
  output logic busy_o,
  output logic latch_o
);
  seq_state_e state;
  logic       req_lvl;
  logic       req_fall;
  logic       acq_done;
  logic       conv_done;
  logic       in_acq;
  logic       in_conv;

  assign in_acq  = (state == SEQ_ACQ);
  assign in_conv = (state == SEQ_CONV);

  conv_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (start_req),
    .lvl  (req_lvl),
    .fall (req_fall)
  );

  conv_seq_timer #(.LIMIT(ACQ_CYC)) u_acq_timer (
    .clk  (clk),
    .clr  (rst || !in_acq),
    .en   (in_acq),
    .last (acq_done)
  );

  conv_seq_timer #(.LIMIT(CONV_CYC)) u_conv_timer (
    .clk  (clk),
    .clr  (rst || !in_conv),
    .en   (in_conv),
    .last (conv_done)
  );

  conv_seq_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .pwr_down  (pwr_down),
    .req_lvl   (req_lvl),
    .req_fall  (req_fall),
    .acq_done  (acq_done),
    .conv_done (conv_done),
    .state     (state),
    .latch_o   (latch_o)
  );

  assign busy_o = in_conv;
  assign hold_o = in_conv;
endmodule

// File: rtl/conv_seq_chk.sv
module conv_seq_chk #(
  parameter int CONV_CYC = 12
) (
  input logic clk,
  input logic rst,
  input logic pwr_down,
  input logic busy_o,
  input logic latch_o
);
  localparam int LW = $clog2(CONV_CYC + 1) + 1;

  logic [LW-1:0] len_q;

  always_ff @(posedge clk) begin
    if (rst)         len_q <= '0;
    else if (busy_o) len_q <= len_q + 1'b1;
    else             len_q <= '0;
  end

  AST_LATCH_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    latch_o |-> ($past(busy_o) && !busy_o)); // R6
  AST_LATCH_SINGLE: assert property (@(posedge clk) disable iff (rst)
    latch_o |=> !latch_o); // R6
  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (rst)
    ($past(busy_o) && !busy_o) |-> (len_q == LW'(CONV_CYC))); // R4
  AST_BUSY_MAX: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (len_q < LW'(CONV_CYC))); // R4
  AST_PD_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (pwr_down && !busy_o) |=> !busy_o); // R9
endmodule

bind conv_seq conv_seq_chk #(.CONV_CYC(CONV_CYC)) u_conv_seq_chk (
  .clk      (clk),
  .rst      (rst),
  .pwr_down (pwr_down),
  .busy_o   (busy_o),
  .latch_o  (latch_o)
);

// File: tb/test_conv_seq.sv
module test_conv_seq;
  localparam int ACQ  = 8;
  localparam int CONV = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_req = 1'b0;
  logic pwr_down = 1'b0;
  logic hold_o, busy_o, latch_o;

  int total = 0;
  int bad = 0;
  int observed = 0;
  int exp_q[$];
  bit finished = 1'b0;

  always #2 clk = ~clk;

  conv_seq #(.ACQ_CYC(ACQ), .CONV_CYC(CONV)) i_conv_seq (
    .clk(clk), .rst(rst), .start_req(start_req), .pwr_down(pwr_down),
    .hold_o(hold_o), .busy_o(busy_o), .latch_o(latch_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // driver side: one expected busy length per conversion that must complete
  task automatic expect_conv();
    exp_q.push_back(CONV);
  endtask

  task automatic count_to_busy(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!busy_o && n < 1000);
  endtask

  task automatic wait_busy_low();
    while (busy_o) @(negedge clk);
  endtask

  // monitor: measures busy pulses and pops expectations
  int  len = 0;
  bit  prev_busy = 1'b0;
  always @(negedge clk) begin
    if (rst) begin
      len = 0;
      prev_busy = 1'b0;
    end else begin
      check(hold_o == busy_o, "R5 hold follows busy", hold_o, busy_o);
      if (busy_o) len++;
      if (prev_busy && !busy_o) begin
        check(latch_o == 1'b1, "R6 strobe on busy fall", latch_o, 1);
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected conversion", len, 0);
        end else begin
          int e;
          e = exp_q.pop_front();
          check(len == e, "R4 busy length", len, e);
        end
        observed++;
        len = 0;
      end else if (latch_o) begin
        check(1'b0, "R6 strobe without busy fall", 1, 0);
      end
      prev_busy = busy_o;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int n;
    int seen;
    repeat (4) @(negedge clk);
    check(!busy_o && !hold_o && !latch_o, "R1 reset outputs", busy_o + hold_o + latch_o, 0);

    // R2: immediate start from reset
    expect_conv();
    rst = 1'b0;
    @(negedge clk);
    check(!busy_o && !hold_o && !latch_o, "R1 first cycle after reset", busy_o, 0);
    count_to_busy(n);
    check(n == ACQ - 1, "R2 immediate start latency", n + 1, ACQ);

    // R7: automatic re-acquisition
    expect_conv();
    wait_busy_low();
    count_to_busy(n);
    check(n == ACQ, "R7 gap between conversions", n, ACQ);

    // R3: request high at end of acquisition -> wait for falling edge
    start_req = 1'b1;
    wait_busy_low();
    seen = 0;
    repeat (40) begin
      @(negedge clk);
      if (busy_o) seen++;
    end
    check(seen == 0, "R3 no start while request high", seen, 0);
    expect_conv();
    start_req = 1'b0;
    count_to_busy(n);
    check(n == 3, "R3 falling-edge start latency", n, 3);

    // R9: power-down during a conversion
    repeat (3) @(negedge clk);
    pwr_down = 1'b1;
    wait_busy_low();
    seen = 0;
    repeat (60) begin
      @(negedge clk);
      if (busy_o) seen++;
    end
    check(seen == 0, "R9 no conversion in power-down", seen, 0);
    check(observed == 3, "R9 running conversion completed", observed, 3);

    // R10: restart after power-down
    expect_conv();
    pwr_down = 1'b0;
    count_to_busy(n);
    check(n == ACQ + 1, "R10 restart latency", n, ACQ + 1);

    // R8: reset aborts the next conversion
    wait_busy_low();
    count_to_busy(n);
    check(n == ACQ, "R7 gap after restart", n, ACQ);
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(!busy_o && !hold_o, "R8 abort clears busy and hold", busy_o + hold_o, 0);
    check(!latch_o, "R8 no strobe on abort", latch_o, 0);
    @(negedge clk);
    check(!latch_o, "R8 no strobe after abort", latch_o, 0);

    // R2 again after an abort, then stop with power-down
    expect_conv();
    rst = 1'b0;
    count_to_busy(n);
    check(n == ACQ, "R2 start latency after abort", n, ACQ);
    pwr_down = 1'b1;
    wait_busy_low();
    repeat (30) @(negedge clk);
    check(exp_q.size() == 0, "R4 all conversions completed", exp_q.size(), 0);
    check(observed == 5, "R8 aborted conversion not counted", observed, 5);
    finish_run();
  end
endmodule